// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block decides, cycle by cycle, whether a small processor core must leave its current instruction stream for an exception handler, and it keeps the processor status word in step with that decision. It watches a fast and a normal interrupt request, three synchronous instruction events (supervisor call, undefined instruction, instruction-fetch abort) and a data-access abort. Each event has a fixed target mode and a fixed slot in a vector table placed at a high base address. On entry the block switches the mode, masks interrupts, copies the old status into a status save slot owned by the target mode, and records a link value for that mode.

It also carries out the handler's return request. The return restores the status from the save slot of the current mode and redirects fetch to the stored link value minus four. Software running in a privileged mode can rewrite the condition flags, the two mask bits and the mode field. A user-mode program can rewrite only the flags. After reset the block starts in a boot mode with both interrupt sources masked, and it fetches from the first vector slot.

The core samples the one-cycle redirect strobe together with the target address and the link value. It reads the current status word and the save slot of the current mode as plain outputs.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted the status word reads 0x000000D2, which is the boot mode 5'b10010 with I (bit 7) and F (bit 6) set. All save slots read zero. In the first clock cycle after reset is released the block enters at the base address 0xFFFF0000 with link value 0, and it ignores every other input in that cycle.
- R2: In a privileged mode a software write changes flags [31:28], I [7], F [6] and mode [4:0] at the next edge. The other bits read zero. A mode value outside the seven valid encodings leaves the mode field unchanged.
- R3: The target modes are fixed: supervisor call goes to 5'b10011, undefined instruction to 5'b11011, fetch abort and data abort to 5'b10111, normal interrupt to 5'b10010 and fast interrupt to 5'b10001. User mode is 5'b10000 and system mode is 5'b11111.
- R4: An event sampled at one edge raises the redirect strobe for exactly that one following cycle. The target address is 0xFFFF0000 plus an offset: undefined 0x04, supervisor call 0x08, fetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R5: On entry the save slot of the target mode receives the old status word. I is set. F is set on fast-interrupt entry and is otherwise kept. The flags are kept. The save-slot output always shows the slot of the current mode, and it reads zero in user and system mode.
- R6: The link value is the current PC plus 8 for a supervisor call or an undefined instruction, and the PC plus 4 for interrupts and aborts.
- R7: A normal interrupt is not taken while I is 1, and a fast interrupt is not taken while F is 1. Synchronous events and aborts are never masked, so a handler that clears F can be preempted by a fast interrupt.
- R8: When several inputs are active in one cycle, the order of precedence is: data abort, fast interrupt, normal interrupt, fetch abort, undefined instruction, supervisor call, return, software write. The lower-ranked inputs in that cycle are dropped.
- R9: A return request in an exception mode redirects to that mode's stored link minus 4, and it reloads the status word from that mode's save slot.
- R10: In user mode a software write changes only the flags. A return request in user or system mode is ignored: there is no redirect and the status is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fiqReq | input | 1 | Fast interrupt request level |
| irqReq | input | 1 | Normal interrupt request level |
| svcStb | input | 1 | Supervisor-call instruction strobe |
| undefStb | input | 1 | Undefined-instruction strobe |
| pabtStb | input | 1 | Instruction-fetch abort strobe |
| dabtStb | input | 1 | Data-access abort strobe |
| pcIn | input | ADDR_W | PC of the instruction being executed |
| retStb | input | 1 | Exception-return request |
| wrStb | input | 1 | Software status-word write strobe |
| wrData | input | 32 | Status word value to write |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| tgtAddr | output | ADDR_W | Vector or return address |
| linkOut | output | ADDR_W | Link value recorded or used |
| cpsrOut | output | 32 | Current status word |
| spsrOut | output | 32 | Save slot of the current mode |

## Verification
Every result of this block is registered. An event, return or write presented before a clock edge shows up on the redirect strobe, the target and link outputs and the status and save-slot outputs one cycle later. The single exception is the boot entry, which takes effect in the first cycle after reset is released. The bench drives inputs on the falling edge and predicts the outcome from an independent model of the requirements. It queues that prediction, and a monitor takes it off the queue and compares it one nanosecond after the next rising edge. In this way each comparison lands in the single cycle where the result is due. Masked interrupts and ignored writes or returns are checked on that same cycle: they must show no redirect and an unchanged status word.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  localparam int          NBANK     = 5;
  localparam int          BANK_W    = $clog2(NBANK);
  localparam logic [BANK_W-1:0] BANK_NONE = '1;

  // Status word layout
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;

  typedef enum logic [2:0] {
    K_NONE, K_RESET, K_UNDEF, K_SVC, K_PABT, K_DABT, K_IRQ, K_FIQ
  } excKind_t;

  typedef struct packed {
    logic     take;
    excKind_t kind;
    logic     doRet;
    logic     doWr;
  } ctlStrb_t;

  function automatic logic [4:0] kindMode(excKind_t k);
    case (k)
      K_FIQ:          return M_FIQ;
      K_IRQ:          return M_IRQ;
      K_PABT, K_DABT: return M_ABT;
      K_UNDEF:        return M_UND;
      default:        return M_SVC;
    endcase
  endfunction

  function automatic logic [7:0] kindOffset(excKind_t k);
    case (k)
      K_UNDEF: return 8'h04;
      K_SVC:   return 8'h08;
      K_PABT:  return 8'h0C;
      K_DABT:  return 8'h10;
      K_IRQ:   return 8'h18;
      K_FIQ:   return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] modeBank(logic [4:0] m);
    case (m)
      M_FIQ:   return BANK_W'(0);
      M_IRQ:   return BANK_W'(1);
      M_SVC:   return BANK_W'(2);
      M_ABT:   return BANK_W'(3);
      M_UND:   return BANK_W'(4);
      default: return BANK_NONE;
    endcase
  endfunction

  function automatic logic isKnownMode(logic [4:0] m);
    return (modeBank(m) != BANK_NONE) || (m == M_USR) || (m == M_SYS);
  endfunction

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fiqReq,
  input  logic       irqReq,
  input  logic       svcStb,
  input  logic       undefStb,
  input  logic       pabtStb,
  input  logic       dabtStb,
  input  logic       retStb,
  input  logic       wrStb,
  input  logic [4:0] curMode,
  input  logic       maskI,
  input  logic       maskF,
  output ctlStrb_t   ctlS
);

  logic bootPend;

  // Boot entry is owed exactly once after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootPend <= 1'b1;
    else       bootPend <= 1'b0;
  end

  logic retAllowed;
  assign retAllowed = (modeBank(curMode) != BANK_NONE);

  // Fixed precedence chain
  always_comb begin
    ctlS = '0;
    ctlS.kind = K_NONE;
    if (bootPend) begin
      ctlS.take = 1'b1;
      ctlS.kind = K_RESET;
    end else if (dabtStb) begin
      ctlS.take = 1'b1;
      ctlS.kind = K_DABT;
    end else if (fiqReq && !maskF) begin
      ctlS.take = 1'b1;
      ctlS.kind = K_FIQ;
    end else if (irqReq && !maskI) begin
      ctlS.take = 1'b1;
      ctlS.kind = K_IRQ;
    end else if (pabtStb) begin
      ctlS.take = 1'b1;
      ctlS.kind = K_PABT;
    end else if (undefStb) begin
      ctlS.take = 1'b1;
      ctlS.kind = K_UNDEF;
    end else if (svcStb) begin
      ctlS.take = 1'b1;
      ctlS.kind = K_SVC;
    end else if (retStb && retAllowed) begin
      ctlS.doRet = 1'b1;
    end else if (wrStb) begin
      ctlS.doWr = 1'b1;
    end
  end

endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int               ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 32'hFFFF0000,
  parameter logic [4:0]       BOOT_MODE = 5'b10010
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          ctlS,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [31:0]       wrData,
  output logic [31:0]       cpsrQ,
  output logic [31:0]       spsrOut,
  output logic              redirect,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [ADDR_W-1:0] linkOut
);

  localparam logic [31:0] CPSR_RST = {4'b0, 20'b0, 1'b1, 1'b1, 1'b0, BOOT_MODE};

  logic [31:0]       spsrBank [NBANK];
  logic [ADDR_W-1:0] linkBank [NBANK];

  logic [4:0]        entMode;
  logic [BANK_W-1:0] entBank;
  logic [BANK_W-1:0] curBank;
  logic [ADDR_W-1:0] linkVal;
  logic [ADDR_W-1:0] vecAddr;
  logic              entF;
  logic [31:0]       spsrSel;
  logic [ADDR_W-1:0] linkSel;
  logic [31:0]       wrNext;

  assign entMode = (ctlS.kind == K_RESET) ? BOOT_MODE : kindMode(ctlS.kind);
  assign entBank = modeBank(entMode);
  assign curBank = modeBank(cpsrQ[4:0]);
  assign vecAddr = VEC_BASE + ADDR_W'(kindOffset(ctlS.kind));
  assign entF    = cpsrQ[BIT_F] | (ctlS.kind == K_FIQ) | (ctlS.kind == K_RESET);

  always_comb begin
    case (ctlS.kind)
      K_RESET:        linkVal = '0;
      K_SVC, K_UNDEF: linkVal = pcIn + ADDR_W'(8);
      default:        linkVal = pcIn + ADDR_W'(4);
    endcase
  end

  always_comb begin
    spsrSel = '0;
    linkSel = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (curBank == BANK_W'(b)) begin
        spsrSel = spsrBank[b];
        linkSel = linkBank[b];
      end
    end
  end
  assign spsrOut = spsrSel;

  // Software write: flags always, masks and mode only when privileged
  always_comb begin
    wrNext = cpsrQ;
    wrNext[31:28] = wrData[31:28];
    if (cpsrQ[4:0] != M_USR) begin
      wrNext[BIT_I] = wrData[BIT_I];
      wrNext[BIT_F] = wrData[BIT_F];
      if (isKnownMode(wrData[4:0])) wrNext[4:0] = wrData[4:0];
    end
  end

  // Per-mode save slots
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        spsrBank[b] <= '0;
        linkBank[b] <= '0;
      end else if (ctlS.take && ctlS.kind != K_RESET && entBank == BANK_W'(b)) begin
        spsrBank[b] <= cpsrQ;
        linkBank[b] <= linkVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpsrQ    <= CPSR_RST;
      redirect <= 1'b0;
      tgtAddr  <= '0;
      linkOut  <= '0;
    end else if (ctlS.take) begin
      cpsrQ    <= {cpsrQ[31:28], 20'b0, 1'b1, entF, 1'b0, entMode};
      redirect <= 1'b1;
      tgtAddr  <= vecAddr;
      linkOut  <= linkVal;
    end else if (ctlS.doRet) begin
      cpsrQ    <= spsrSel;
      redirect <= 1'b1;
      tgtAddr  <= linkSel - ADDR_W'(4);
      linkOut  <= linkSel;
    end else begin
      redirect <= 1'b0;
      if (ctlS.doWr) cpsrQ <= wrNext;
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 32'hFFFF0000,
  parameter logic [4:0]        BOOT_MODE = 5'b10010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fiqReq,
  input  logic              irqReq,
  input  logic              svcStb,
  input  logic              undefStb,
  input  logic              pabtStb,
  input  logic              dabtStb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              retStb,
  input  logic              wrStb,
  input  logic [31:0]       wrData,
  output logic              redirect,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [ADDR_W-1:0] linkOut,
  output logic [31:0]       cpsrOut,
  output logic [31:0]       spsrOut
);

  ctlStrb_t ctlS;

  exc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fiqReq   (fiqReq),
    .irqReq   (irqReq),
    .svcStb   (svcStb),
    .undefStb (undefStb),
    .pabtStb  (pabtStb),
    .dabtStb  (dabtStb),
    .retStb   (retStb),
    .wrStb    (wrStb),
    .curMode  (cpsrOut[4:0]),
    .maskI    (cpsrOut[BIT_I]),
    .maskF    (cpsrOut[BIT_F]),
    .ctlS     (ctlS)
  );

  exc_datapath #(
    .ADDR_W    (ADDR_W),
    .VEC_BASE  (VEC_BASE),
    .BOOT_MODE (BOOT_MODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctlS     (ctlS),
    .pcIn     (pcIn),
    .wrData   (wrData),
    .cpsrQ    (cpsrOut),
    .spsrOut  (spsrOut),
    .redirect (redirect),
    .tgtAddr  (tgtAddr),
    .linkOut  (linkOut)
  );

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        dabtStb,
  input ctlStrb_t    ctlS,
  input logic        redirect,
  input logic [31:0] cpsrOut,
  input logic [31:0] spsrOut
);

  // R4
  entry_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlS.take |=> redirect);

  // R5
  entry_mask_i_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlS.take |=> cpsrOut[BIT_I]);

  // R3
  fiq_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlS.take && ctlS.kind == K_FIQ) |=> (cpsrOut[4:0] == M_FIQ && cpsrOut[BIT_F]));

  // R7
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlS.take && ctlS.kind == K_IRQ) |-> !cpsrOut[BIT_I]);

  // R8
  dabt_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dabtStb && ctlS.kind != K_RESET) |-> (ctlS.take && ctlS.kind == K_DABT));

  // R9
  return_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlS.doRet |=> (cpsrOut == $past(spsrOut)));

  // R10
  user_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpsrOut[4:0] == M_USR && !ctlS.take) |=> (cpsrOut[4:0] == M_USR));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dabtStb  (dabtStb),
  .ctlS     (ctlS),
  .redirect (redirect),
  .cpsrOut  (cpsrOut),
  .spsrOut  (spsrOut)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;

  localparam logic [31:0] BASE = 32'hFFFF0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fiqReq = 0, irqReq = 0, svcStb = 0, undefStb = 0, pabtStb = 0, dabtStb = 0;
  logic        retStb = 0, wrStb = 0;
  logic [31:0] pcIn = '0, wrData = '0;
  logic        redirect;
  logic [31:0] tgtAddr, linkOut, cpsrOut, spsrOut;

  always #2 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rstN(rstN), .fiqReq(fiqReq), .irqReq(irqReq), .svcStb(svcStb),
    .undefStb(undefStb), .pabtStb(pabtStb), .dabtStb(dabtStb), .pcIn(pcIn),
    .retStb(retStb), .wrStb(wrStb), .wrData(wrData), .redirect(redirect),
    .tgtAddr(tgtAddr), .linkOut(linkOut), .cpsrOut(cpsrOut), .spsrOut(spsrOut)
  );

  typedef struct {
    string       tag;
    logic        redir;
    logic [31:0] tgt;
    logic [31:0] link;
    logic [31:0] cpsr;
    logic [31:0] spsr;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;

  // Reference model state
  logic [31:0] mCpsr = 32'h000000D2;
  logic [31:0] mSpsr [5];
  logic [31:0] mLink [5];
  logic [31:0] mTgt = '0, mLinkOut = '0;
  logic        mBoot = 1'b1;

  function automatic int bankOf(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  task automatic cyc(input logic f, i, s, u, pa, da, ret, wr,
                     input logic [31:0] wd, input logic [31:0] pc, input string tag);
    expItem_t e;
    logic [4:0] tm;
    logic [7:0] off;
    logic [31:0] lk;
    logic hit;
    int b;
    fiqReq = f; irqReq = i; svcStb = s; undefStb = u; pabtStb = pa; dabtStb = da;
    retStb = ret; wrStb = wr; wrData = wd; pcIn = pc;
    e.tag = tag;
    e.redir = 1'b0;
    hit = 1'b1; tm = 5'b10011; off = 8'h08; lk = pc + 8;
    if (mBoot) begin
      mBoot = 1'b0; e.redir = 1'b1; mTgt = BASE; mLinkOut = 32'h0;
      hit = 1'b0;
    end else if (da) begin tm = 5'b10111; off = 8'h10; lk = pc + 4;
    end else if (f && !mCpsr[6]) begin tm = 5'b10001; off = 8'h1C; lk = pc + 4;
    end else if (i && !mCpsr[7]) begin tm = 5'b10010; off = 8'h18; lk = pc + 4;
    end else if (pa) begin tm = 5'b10111; off = 8'h0C; lk = pc + 4;
    end else if (u) begin tm = 5'b11011; off = 8'h04; lk = pc + 8;
    end else if (s) begin tm = 5'b10011; off = 8'h08; lk = pc + 8;
    end else begin
      hit = 1'b0;
      b = bankOf(mCpsr[4:0]);
      if (ret && b >= 0) begin
        e.redir = 1'b1; mTgt = mLink[b] - 4; mLinkOut = mLink[b]; mCpsr = mSpsr[b];
      end else if (wr) begin
        mCpsr[31:28] = wd[31:28];
        if (mCpsr[4:0] != 5'b10000) begin
          mCpsr[7:6] = wd[7:6];
          if (bankOf(wd[4:0]) >= 0 || wd[4:0] == 5'b10000 || wd[4:0] == 5'b11111)
            mCpsr[4:0] = wd[4:0];
        end
      end
    end
    if (hit) begin
      b = bankOf(tm);
      mSpsr[b] = mCpsr; mLink[b] = lk;
      mCpsr = {mCpsr[31:28], 20'b0, 1'b1, mCpsr[6] | (tm == 5'b10001), 1'b0, tm};
      e.redir = 1'b1; mTgt = BASE + {24'b0, off}; mLinkOut = lk;
    end
    e.tgt = mTgt; e.link = mLinkOut; e.cpsr = mCpsr;
    b = bankOf(mCpsr[4:0]);
    e.spsr = (b >= 0) ? mSpsr[b] : 32'h0;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        nChecks++;
        if (redirect !== e.redir || tgtAddr !== e.tgt || linkOut !== e.link ||
            cpsrOut !== e.cpsr || spsrOut !== e.spsr) begin
          nFails++;
          $display("FAIL %s: redir/tgt/link/cpsr/spsr actual %0b %h %h %h %h expected %0b %h %h %h %h",
                   e.tag, redirect, tgtAddr, linkOut, cpsrOut, spsrOut,
                   e.redir, e.tgt, e.link, e.cpsr, e.spsr);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(4 * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) begin mSpsr[k] = '0; mLink[k] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    nChecks++;
    if (cpsrOut !== 32'h000000D2 || spsrOut !== 32'h0 || redirect !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: cpsr/spsr/redir actual %h %h %0b expected 000000d2 0 0",
               cpsrOut, spsrOut, redirect);
    end
    rstN = 1'b1;
    //   f i s u pa da ret wr
    cyc(0,0,1,0,0,0,0,0, 32'h0, 32'h40, "R1 boot entry");
    cyc(0,0,0,0,0,0,0,1, 32'h00000013, 32'h0, "R2 priv write to supervisor");
    cyc(0,0,0,0,0,0,0,1, 32'hF000001A, 32'h0, "R2 bad mode kept");
    cyc(0,0,1,0,0,0,0,0, 32'h0, 32'h100, "R3 R4 R6 supervisor call");
    cyc(0,0,0,0,0,0,1,0, 32'h0, 32'h0, "R9 return from call");
    cyc(0,1,0,0,0,0,0,0, 32'h0, 32'h200, "R3 R4 R6 irq entry");
    cyc(0,1,0,0,0,0,0,0, 32'h0, 32'h204, "R7 irq masked");
    cyc(1,0,0,0,0,0,0,0, 32'h0, 32'h300, "R5 R7 fiq preempts irq");
    cyc(0,0,0,0,0,0,1,0, 32'h0, 32'h0, "R9 return fiq");
    cyc(0,0,0,0,0,0,1,0, 32'h0, 32'h0, "R9 return irq");
    cyc(1,1,1,0,0,1,0,0, 32'h0, 32'h400, "R8 dabt wins");
    cyc(0,0,0,0,0,0,1,0, 32'h0, 32'h0, "R9 return abort");
    cyc(1,1,0,0,1,0,0,0, 32'h0, 32'h500, "R8 fiq over irq and pabt");
    cyc(0,0,0,0,0,0,1,0, 32'h0, 32'h0, "R9 return fiq2");
    cyc(0,0,0,0,1,0,0,1, 32'h00000010, 32'h600, "R8 pabt over write");
    cyc(0,0,0,0,0,0,1,0, 32'h0, 32'h0, "R9 return pabt");
    cyc(0,0,0,0,0,0,0,1, 32'h00000010, 32'h0, "R2 write to user");
    cyc(0,0,0,0,0,0,0,1, 32'h800000D3, 32'h0, "R10 user write flags only");
    cyc(0,0,0,0,0,0,1,0, 32'h0, 32'h0, "R10 user return ignored");
    cyc(0,0,0,0,0,0,0,0, 32'h0, 32'h0, "R4 strobe one cycle");
    cyc(0,0,0,1,0,0,0,0, 32'h0, 32'h700, "R3 R4 R6 undefined");
    cyc(0,0,0,0,0,0,0,1, 32'h0000005F, 32'h0, "R2 write to system F set");
    cyc(0,0,0,0,0,0,1,0, 32'h0, 32'h0, "R10 system return ignored");
    cyc(1,0,0,0,0,0,0,0, 32'h0, 32'h800, "R7 fiq masked by F");
    cyc(0,1,0,0,0,0,0,0, 32'h0, 32'h900, "R5 irq entry keeps F");
    cyc(0,0,0,0,0,0,0,0, 32'h0, 32'h0, "R4 idle");
    @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule